// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Register Bank

This block holds the configuration of a fixed set of hardware breakpoint triggers and makes it reachable through three control-register slots. One slot is a select index that names the trigger in view; the other two show that trigger's configuration word and its comparison value. The comparators that use these settings sit elsewhere. The bank feeds them every trigger's configuration and comparison value in parallel.

Every data register keeps write-any-read-legal behaviour. A write carrying an unsupported value is turned into a supported one before it is stored, and reads return the stored legal value. The select index is only as wide as the trigger count needs. A debugger that writes an index and reads it back can therefore count the triggers. An index that names a trigger beyond the configured count reads back as a trigger of type 0 and ignores writes. A bank built with no triggers flags every access as illegal.

The configuration word uses these fields: the trigger type in bits [31:28], the debug-only ownership bit at bit 27, the action code in bits [15:12], and match enables in bits [2:0] (bit 2 execute, bit 1 store, bit 0 load). All other bits read as zero.

Top module: `trig_bank`

## Requirements
- R1: After reset the select index is 0. Each existing trigger reads configuration 0x2000_0000 (type 2, ownership bit 0, action 0, enables 0) and comparison value 0.
- R2: The select index stores only its low IDX_W bits, with IDX_W = clog2(NUM_TRIG). With 4 triggers, writing 7 reads back 3.
- R3: When the select index names a trigger at or beyond NUM_TRIG, the configuration and comparison slots read 0, so the type reads as 0. Writes to those slots change nothing.
- R4: A write to the configuration or comparison slot changes only that register of the selected trigger. Every other register and every other trigger keeps its value.
- R5: An action code other than 0 or 1 is stored as 0.
- R6: Action 1 (halt into debug) is stored only when the resulting ownership bit is 1. Otherwise the action becomes 0.
- R7: A write that clears the ownership bit while asking for action 1 stores action 0, even when action 1 was held before.
- R8: Only a write made while dbg_mode_i is 1 can change the ownership bit. A write made in normal mode leaves the bit at its old value.
- R9: The type field cannot be written. All bits outside type, ownership, action and enables read 0.
- R10: Address 3 is unmapped, and any request to it raises csr_illegal_o. With NUM_TRIG = 0, every request raises csr_illegal_o. An illegal access reads 0 and changes no state.
- R11: Read data follows the address combinationally, in the same cycle as the request. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode_i | input | 1 | Access originates from debug mode |
| csr_req_i | input | 1 | Register access valid this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 2 | 0 select, 1 configuration, 2 comparison value, 3 unmapped |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data for the current access |
| csr_illegal_o | output | 1 | Access is not allowed |
| trig_cfg_o | output | 32*max(NUM_TRIG,1) | Configuration word of every trigger, trigger 0 in the low bits |
| trig_addr_o | output | 32*max(NUM_TRIG,1) | Comparison value of every trigger, trigger 0 in the low bits |

## Verification
The assertions assume that csr_we_i only matters while csr_req_i is high. They also assume dbg_mode_i is a clean level, held steady across each access. The bench drives every request at the falling edge and keeps all inputs steady until the next falling edge, so each write happens on exactly one rising edge. A second and a third instance, built with three triggers and with none, cover the missing-trigger and no-trigger cases; no input sequence could reach these on the four-trigger bank.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int unsigned CFG_W      = 32;
  localparam int unsigned TYPE_LSB   = 28;
  localparam int unsigned OWN_BIT    = 27;
  localparam int unsigned ACT_LSB    = 12;
  localparam int unsigned EN_W       = 3;
  localparam logic [3:0]  TYPE_ADDR  = 4'd2;

  typedef enum logic [1:0] {
    SLOT_SEL  = 2'd0,
    SLOT_CFG  = 2'd1,
    SLOT_CMP  = 2'd2,
    SLOT_RSVD = 2'd3
  } slot_e;

  typedef struct packed {
    logic            own;
    logic            act;
    logic [EN_W-1:0] en;
  } cfg_t;

  // Turn any written word into a supported configuration.
  function automatic cfg_t legalize(input logic old_own, input logic [CFG_W-1:0] wd,
                                    input logic dbg);
    cfg_t r;
    logic [3:0] act_req;
    r.own   = dbg ? wd[OWN_BIT] : old_own;
    act_req = wd[ACT_LSB +: 4];
    r.act   = (act_req == 4'd1) && r.own;
    r.en    = wd[EN_W-1:0];
    return r;
  endfunction

  function automatic logic [CFG_W-1:0] pack_cfg(input cfg_t c);
    logic [CFG_W-1:0] w;
    w                 = '0;
    w[TYPE_LSB +: 4]  = TYPE_ADDR;
    w[OWN_BIT]        = c.own;
    w[ACT_LSB +: 4]   = {3'b000, c.act};
    w[EN_W-1:0]       = c.en;
    return w;
  endfunction

endpackage

// File: rtl/trig_sel_reg.sv
module trig_sel_reg #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] sel_o
);

  logic [IDX_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (we) sel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel_q <= '0;
    else if (we) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  AST_SEL_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> sel_o == $past(wdata)); // R2

endmodule

// File: rtl/trig_slot.sv
module trig_slot
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cmp_we,
  input  logic             dbg_mode,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CFG_W-1:0] cmp_o
);

  cfg_t             cfg_q, cfg_d;
  logic [CFG_W-1:0] cmp_q, cmp_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = legalize(cfg_q.own, wdata, dbg_mode);
  end

  always_comb begin
    cmp_d = cmp_q;
    if (cmp_we) cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_d;
  end

  assign cfg_o = pack_cfg(cfg_q);
  assign cmp_o = cmp_q;

  AST_HALT_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[ACT_LSB] |-> cfg_o[OWN_BIT]); // R6

  AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[ACT_LSB+1 +: 3] == 3'b000); // R5

  AST_OWN_DROP_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && dbg_mode && !wdata[OWN_BIT] |=> !cfg_o[ACT_LSB]); // R7

  AST_NORMAL_OWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !dbg_mode |=> $stable(cfg_o[OWN_BIT])); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we && !cmp_we |=> $stable(cfg_o) && $stable(cmp_o)); // R4

endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  localparam int unsigned NT_ST   = (NUM_TRIG == 0) ? 1 : NUM_TRIG,
  localparam int unsigned IDX_W   = (NUM_TRIG <= 1) ? 1 : $clog2(NUM_TRIG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dbg_mode_i,
  input  logic                   csr_req_i,
  input  logic                   csr_we_i,
  input  logic [1:0]             csr_addr_i,
  input  logic [31:0]            csr_wdata_i,
  output logic [31:0]            csr_rdata_o,
  output logic                   csr_illegal_o,
  output logic [NT_ST*32-1:0]    trig_cfg_o,
  output logic [NT_ST*32-1:0]    trig_addr_o
);

  localparam logic HAS_TRIG = (NUM_TRIG != 0);

  logic             illegal;
  logic             wr_ok;
  logic [IDX_W-1:0] sel;
  logic [31:0]      cfg_w [NT_ST];
  logic [31:0]      cmp_w [NT_ST];

  assign illegal = csr_req_i && (!HAS_TRIG || (csr_addr_i == SLOT_RSVD));
  assign wr_ok   = csr_req_i && csr_we_i && !illegal;

  trig_sel_reg #(.IDX_W(IDX_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_ok && (csr_addr_i == SLOT_SEL)),
    .wdata (csr_wdata_i[IDX_W-1:0]),
    .sel_o (sel)
  );

  for (genvar i = 0; i < NT_ST; i++) begin : g_trig
    if (i < NUM_TRIG) begin : g_real
      logic hit;
      assign hit = (sel == IDX_W'(i));
      trig_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (wr_ok && hit && (csr_addr_i == SLOT_CFG)),
        .cmp_we   (wr_ok && hit && (csr_addr_i == SLOT_CMP)),
        .dbg_mode (dbg_mode_i),
        .wdata    (csr_wdata_i),
        .cfg_o    (cfg_w[i]),
        .cmp_o    (cmp_w[i])
      );
    end else begin : g_none
      assign cfg_w[i] = '0;
      assign cmp_w[i] = '0;
    end
    assign trig_cfg_o[i*32 +: 32]  = cfg_w[i];
    assign trig_addr_o[i*32 +: 32] = cmp_w[i];
  end

  // Selected trigger view; indices with no trigger read zero.
  always_comb begin
    logic [31:0] cfg_sel, cmp_sel;
    cfg_sel = '0;
    cmp_sel = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (sel == IDX_W'(i)) begin
        cfg_sel = cfg_w[i];
        cmp_sel = cmp_w[i];
      end
    end
    csr_rdata_o = '0;
    if (csr_req_i && !illegal) begin
      unique case (csr_addr_i)
        SLOT_SEL: csr_rdata_o = 32'(sel);
        SLOT_CFG: csr_rdata_o = cfg_sel;
        SLOT_CMP: csr_rdata_o = cmp_sel;
        default:  csr_rdata_o = '0;
      endcase
    end
  end

  assign csr_illegal_o = illegal;

  AST_RSVD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req_i && (csr_addr_i == SLOT_RSVD) |-> csr_illegal_o); // R10

  AST_ILLEGAL_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal_o |=> $stable(sel)); // R10

  AST_ILLEGAL_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal_o |-> csr_rdata_o == '0); // R10

endmodule

// File: tb/trig_bank_tb_top.sv
module trig_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  // {wr, dbg, addr[1:0], wdata[31:0], expected[31:0]}
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'd0, 32'h0000_0000, 32'h0},
    {1'b1, 1'b1, 2'd1, 32'h0800_1007, 32'h0},
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2800_1007},  // R6 own set, halt kept
    {1'b1, 1'b1, 2'd1, 32'h0000_1005, 32'h0},
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2000_0005},  // R7
    {1'b1, 1'b0, 2'd1, 32'h0800_1001, 32'h0},
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2000_0001},  // R8 R6
    {1'b1, 1'b1, 2'd1, 32'h0800_3000, 32'h0},
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2800_0000},  // R5
    {1'b1, 1'b0, 2'd1, 32'h0000_1000, 32'h0},
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2800_1000},  // R8 own kept
    {1'b1, 1'b1, 2'd1, 32'hFFFF_FFF8, 32'h0},
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2800_0000},  // R9 R5
    {1'b1, 1'b1, 2'd2, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 1'b0, 2'd2, 32'h0,         32'hDEAD_BEEF},  // R4
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2800_0000},  // R4 cfg kept
    {1'b1, 1'b1, 2'd0, 32'h0000_0001, 32'h0},
    {1'b0, 1'b0, 2'd1, 32'h0,         32'h2000_0000},  // R4 trigger 1
    {1'b0, 1'b0, 2'd2, 32'h0,         32'h0},          // R4
    {1'b1, 1'b1, 2'd0, 32'h0000_0007, 32'h0},
    {1'b0, 1'b0, 2'd0, 32'h0,         32'h0000_0003}   // R2
  };

  logic        clk, rst_n, dbg, we;
  logic [1:0]  addr;
  logic [31:0] wd;
  logic        req4, req3, req0;
  logic [31:0] rd4, rd3, rd0;
  logic        il4, il3, il0;
  logic [127:0] cfg4, cmp4;
  logic [95:0]  cfg3, cmp3;
  logic [31:0]  cfg0, cmp0;
  int n_chk, n_fail;

  trig_bank #(.NUM_TRIG(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_mode_i(dbg), .csr_req_i(req4), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wd), .csr_rdata_o(rd4), .csr_illegal_o(il4),
    .trig_cfg_o(cfg4), .trig_addr_o(cmp4));

  trig_bank #(.NUM_TRIG(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .dbg_mode_i(dbg), .csr_req_i(req3), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wd), .csr_rdata_o(rd3), .csr_illegal_o(il3),
    .trig_cfg_o(cfg3), .trig_addr_o(cmp3));

  trig_bank #(.NUM_TRIG(0)) dut0_i (
    .clk(clk), .rst_n(rst_n), .dbg_mode_i(dbg), .csr_req_i(req0), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wd), .csr_rdata_o(rd0), .csr_illegal_o(il0),
    .trig_cfg_o(cfg0), .trig_addr_o(cmp0));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One access: inputs set at the falling edge, read sampled before the rising edge.
  task automatic access(input int which, input logic w, input logic d, input logic [1:0] a,
                        input logic [31:0] data, output logic [31:0] r, output logic ill);
    @(negedge clk);
    req4 = (which == 4); req3 = (which == 3); req0 = (which == 0);
    we = w; dbg = d; addr = a; wd = data;
    #1;
    r   = (which == 4) ? rd4 : (which == 3) ? rd3 : rd0;
    ill = (which == 4) ? il4 : (which == 3) ? il3 : il0;
    @(posedge clk);
    #1;
    req4 = 1'b0; req3 = 1'b0; req0 = 1'b0; we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic ill;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; req4 = 0; req3 = 0; req0 = 0; we = 0; dbg = 0; addr = 0; wd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Reset state
    access(4, 0, 0, 2'd0, 0, r, ill); check("R1 select", r, 32'h0);
    access(4, 0, 0, 2'd1, 0, r, ill); check("R1 cfg", r, 32'h2000_0000);
    check("R1 cfg out t3", cfg4[127:96], 32'h2000_0000);
    check("R1 cmp out t2", cmp4[95:64], 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(4, VEC[i][67], VEC[i][66], VEC[i][65:64], VEC[i][63:32], r, ill);
      if (!VEC[i][67]) check($sformatf("vector %0d (R2/R4-R9)", i), r, VEC[i][31:0]);
    end

    // R4 through the match-side outputs
    check("R4 out t0 cfg", cfg4[31:0], 32'h2800_0000);
    check("R4 out t0 cmp", cmp4[31:0], 32'hDEAD_BEEF);
    check("R4 out t2 cfg", cfg4[95:64], 32'h2000_0000);

    // R11: same-cycle read shows old value, new value after the edge
    access(4, 1, 1, 2'd0, 32'h0, r, ill);
    access(4, 1, 1, 2'd2, 32'h1234_5678, r, ill); check("R11 old value", r, 32'hDEAD_BEEF);
    access(4, 0, 0, 2'd2, 0, r, ill); check("R11 new value", r, 32'h1234_5678);

    // R10: unmapped slot
    access(4, 1, 1, 2'd3, 32'h1, r, ill);
    check("R10 rsvd illegal", {31'b0, ill}, 32'h1);
    check("R10 rsvd rdata", r, 32'h0);
    access(4, 0, 0, 2'd0, 0, r, ill); check("R10 select kept", r, 32'h0);

    // R3: three-trigger bank, index 3 has no trigger
    access(3, 1, 1, 2'd0, 32'h3, r, ill);
    access(3, 0, 0, 2'd0, 0, r, ill); check("R3 sel readback", r, 32'h3);
    access(3, 0, 0, 2'd1, 0, r, ill); check("R3 type 0", r, 32'h0);
    check("R3 legal", {31'b0, ill}, 32'h0);
    access(3, 1, 1, 2'd1, 32'h0800_1007, r, ill);
    access(3, 1, 1, 2'd2, 32'h5555_AAAA, r, ill);
    access(3, 0, 0, 2'd1, 0, r, ill); check("R3 cfg write ignored", r, 32'h0);
    access(3, 0, 0, 2'd2, 0, r, ill); check("R3 cmp write ignored", r, 32'h0);
    check("R3 others unchanged", cfg3[95:64], 32'h2000_0000);
    check("R3 cmp outs zero", cmp3[95:0] == 96'h0 ? 32'h0 : 32'h1, 32'h0);

    // R10: no triggers at all
    access(0, 0, 0, 2'd0, 0, r, ill); check("R10 none read illegal", {31'b0, ill}, 32'h1);
    access(0, 1, 1, 2'd0, 32'h1, r, ill); check("R10 none write illegal", {31'b0, ill}, 32'h1);
    check("R10 none rdata", r, 32'h0);
    check("R10 none outputs", cfg0 | cmp0, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule